// File: doc/BRIEF.md
# SPI-to-NAND Command Bridge

This block is a serial slave that lets a host talk to a parallel 8-bit NAND flash device over a four-wire serial link. Every chip-select frame opens with an opcode byte. The opcode picks one of three jobs for the rest of the frame:
- load a side-band settings register;
- push data bytes onto the NAND bus with write-enable pulses;
- pull bytes off the NAND bus with read-enable pulses and shift them back to the host.

The settings register drives the NAND select, command-latch and address-latch pins, a fan enable, and four active-low indicator outputs. The NAND ready/busy pin is passed straight back to the host side.

All serial pins are sampled in the system clock domain through synchronizers. The host must therefore hold SCK high and low for at least 8 system clocks each. The serial link has no back-pressure of its own, so none is added. Every byte the host clocks in or out is handled at the pace the host sets. The NAND strobe sequence of 5 clocks finishes well inside one byte time.

A write frame cannot tell its last byte from its data bytes until chip select rises. Each data byte is therefore committed to the NAND only when the first bit of the following byte arrives. The final byte of a write frame serves as the response slot and is never written. A read frame works the same way in reverse: a read pulse fires at the end of the last idle slot and at the end of every later slot. Each captured byte goes out in the slot that follows, so the pulse fired at the end of the final slot reads one byte that the host never sees.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the settings register holds 0x8F, so nand_ce_n=1, nand_cle=0, nand_ale=0, fan_en=0 and led_n=4'hF. Both strobes are high and spi_miso is 0.
- R2: Bytes are shifted MSB first, with MOSI sampled on rising SCK. Chip select going high drops any partial byte, and the next frame's first byte is decoded as an opcode.
- R3: Opcode 0x09 loads the byte that follows it into the settings register. The field positions are: bit7 nand_ce_n, bit6 nand_cle, bit5 nand_ale, bit4 fan_en, bits3..0 led_n[3:0]. Any further bytes in that frame are ignored.
- R4: Under opcode 0x08, every byte after the opcode except the final one is driven to the NAND, in order. A byte is driven once the first bit of the next byte has arrived, and the final byte is never driven.
- R5: Each NAND write holds nand_we_n low for exactly 2 system clocks. nand_dq_oe stays high and nand_dq_out stays stable for the whole low phase.
- R6: If dual_lane_en is high when a 0x08 opcode completes, each data byte of that frame takes 4 rising SCK edges. Each edge carries the higher bit on spi_mosi and the next lower bit on spi_mosi2. The opcode itself always uses a single lane.
- R7: Opcode 0x0A is followed by one idle slot. Each later slot returns one NAND byte on spi_miso, MSB first. A 2-clock nand_re_n pulse fires at the end of the last idle slot and at the end of every later slot.
- R8: Opcode 0x0B behaves like 0x0A but is followed by four idle slots.
- R9: After any other opcode, all bytes are ignored until chip select rises.
- R10: host_ready always equals nand_rb.
- R11: spi_miso is 0 in every slot that is not a read-data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host data, primary lane |
| spi_mosi2 | input | 1 | Host data, second lane for dual-lane writes |
| dual_lane_en | input | 1 | Selects two-bit-per-edge write data |
| spi_miso | output | 1 | Data to host |
| nand_dq_out | output | 8 | NAND bus write data |
| nand_dq_oe | output | 1 | NAND bus drive enable |
| nand_dq_in | input | 8 | NAND bus read data |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_ce_n | output | 1 | NAND select, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_rb | input | 1 | NAND ready/busy |
| host_ready | output | 1 | Ready/busy copy for host |
| fan_en | output | 1 | Fan enable |
| led_n | output | 4 | Indicator outputs, active low |

## Verification
The hardest case to reach from the ports is the split between a write frame's data bytes and its response byte. The bridge only learns which byte was last when chip select rises. The bench ends single-lane and dual-lane write frames with a trailing byte and checks that the scoreboard of NAND writes receives the data bytes and nothing more. A chip-select abort in the middle of a byte is also driven, followed at once by a fresh settings frame, to show that the leftover bits were dropped and that decoding restarted at the opcode.

// File: rtl/spn_pkg.sv
package spn_pkg;

  localparam logic [7:0] OP_WRITE = 8'h08;
  localparam logic [7:0] OP_CFG   = 8'h09;
  localparam logic [7:0] OP_READ  = 8'h0A;
  localparam logic [7:0] OP_FREAD = 8'h0B;

  // Settings register; field order is fixed by the host protocol.
  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       fan;
    logic [3:0] led_n;
  } cfg_t;

  localparam cfg_t CFG_RESET = cfg_t'(8'h8F);

  typedef enum logic [2:0] {
    FS_OPC,
    FS_WR,
    FS_CFG,
    FS_RD,
    FS_IGN
  } frame_st_t;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_SETUP,
    SB_LOW,
    SB_HOLD
  } strobe_st_t;

endpackage

// File: rtl/spn_spi_rx.sv
module spn_spi_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic              mosi2_i,
  input  logic              dual_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              act_o,
  output logic              byte_done_o,
  output logic              first_bit_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, d0_sy, d1_sy;
  logic sck_s, sck_d, d0_s, d1_s, rise, fall;
  logic [CNT_W-1:0] cnt, step, cnt_nx;
  logic [DATA_W-1:0] sh, sh_nx, tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      cs_sy  <= '1;
      d0_sy  <= '0;
      d1_sy  <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck_i};
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs_n_i};
      d0_sy  <= {d0_sy[SYNC_STAGES-2:0], mosi_i};
      d1_sy  <= {d1_sy[SYNC_STAGES-2:0], mosi2_i};
      sck_d  <= sck_s;
    end
  end

  assign sck_s  = sck_sy[SYNC_STAGES-1];
  assign d0_s   = d0_sy[SYNC_STAGES-1];
  assign d1_s   = d1_sy[SYNC_STAGES-1];
  assign act_o  = ~cs_sy[SYNC_STAGES-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  assign step   = dual_i ? CNT_W'(2) : CNT_W'(1);
  assign cnt_nx = cnt + step;
  assign sh_nx  = dual_i ? {sh[DATA_W-3:0], d0_s, d1_s} : {sh[DATA_W-2:0], d0_s};
  assign miso_o = tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      rx_byte_o   <= '0;
      byte_done_o <= 1'b0;
      first_bit_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      first_bit_o <= 1'b0;
      if (!act_o) begin
        cnt <= '0;
        sh  <= '0;
        tx  <= '0;
      end else begin
        if (rise) begin
          sh          <= sh_nx;
          first_bit_o <= (cnt == '0);
          if (cnt_nx >= CNT_W'(DATA_W)) begin
            cnt         <= '0;
            byte_done_o <= 1'b1;
            rx_byte_o   <= sh_nx;
          end else begin
            cnt <= cnt_nx;
          end
        end
        if (tx_load_i) tx <= tx_byte_i;
        else if (fall && cnt != '0) tx <= {tx[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R2
  done_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> $past(act_o));

  // R2
  idle_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!act_o) |-> !miso_o);

endmodule

// File: rtl/spn_frame_ctl.sv
module spn_frame_ctl
  import spn_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SLOW_IDLE = 1,
  parameter int FAST_IDLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              byte_done_i,
  input  logic              first_bit_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              dual_sel_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              dual_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output cfg_t              cfg_o
);
  localparam int IDLE_W = $clog2(FAST_IDLE + 1);

  frame_st_t         state;
  logic [IDLE_W-1:0] idle_left;
  logic              pend, dual_q;
  logic [DATA_W-1:0] pend_data;

  assign dual_o = (state == FS_WR) && dual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_OPC;
      idle_left <= '0;
      pend      <= 1'b0;
      pend_data <= '0;
      dual_q    <= 1'b0;
      cfg_o     <= CFG_RESET;
      wr_req_o  <= 1'b0;
      wr_data_o <= '0;
      rd_req_o  <= 1'b0;
      tx_load_o <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      wr_req_o  <= 1'b0;
      rd_req_o  <= 1'b0;
      tx_load_o <= 1'b0;
      if (!act_i) begin
        state     <= FS_OPC;
        pend      <= 1'b0;
        dual_q    <= 1'b0;
        idle_left <= '0;
      end else begin
        if (rd_done_i) begin
          tx_load_o <= 1'b1;
          tx_byte_o <= rd_data_i;
        end
        case (state)
          FS_OPC: if (byte_done_i) begin
            case (rx_byte_i[7:0])
              OP_WRITE: begin
                state  <= FS_WR;
                dual_q <= dual_sel_i;
              end
              OP_CFG:  state <= FS_CFG;
              OP_READ: begin
                state     <= FS_RD;
                idle_left <= IDLE_W'(SLOW_IDLE);
              end
              OP_FREAD: begin
                state     <= FS_RD;
                idle_left <= IDLE_W'(FAST_IDLE);
              end
              default: state <= FS_IGN;
            endcase
          end
          FS_WR: begin
            if (first_bit_i && pend) begin
              wr_req_o  <= 1'b1;
              wr_data_o <= pend_data;
              pend      <= 1'b0;
            end
            if (byte_done_i) begin
              pend      <= 1'b1;
              pend_data <= rx_byte_i;
            end
          end
          FS_CFG: if (byte_done_i) begin
            cfg_o <= cfg_t'(rx_byte_i[7:0]);
            state <= FS_IGN;
          end
          FS_RD: if (byte_done_i) begin
            if (idle_left > IDLE_W'(1)) idle_left <= idle_left - IDLE_W'(1);
            else begin
              idle_left <= '0;
              rd_req_o  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  cfg_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> $past(byte_done_i && act_i));

  // R4
  wr_after_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> $past(first_bit_i));

endmodule

// File: rtl/spn_nand_strobe.sv
module spn_nand_strobe
  import spn_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              oe_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PW = $clog2(STROBE_CYC + 1);

  strobe_st_t    st;
  logic          is_wr;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SB_IDLE;
      is_wr     <= 1'b0;
      cnt       <= '0;
      dout_o    <= '0;
      oe_o      <= 1'b0;
      we_n_o    <= 1'b1;
      re_n_o    <= 1'b1;
      rd_done_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_done_o <= 1'b0;
      case (st)
        SB_IDLE: begin
          if (wr_req_i) begin
            st     <= SB_SETUP;
            is_wr  <= 1'b1;
            dout_o <= wr_data_i;
            oe_o   <= 1'b1;
          end else if (rd_req_i) begin
            st    <= SB_SETUP;
            is_wr <= 1'b0;
          end
        end
        SB_SETUP: begin
          st     <= SB_LOW;
          cnt    <= PW'(STROBE_CYC - 1);
          we_n_o <= !is_wr;
          re_n_o <= is_wr;
        end
        SB_LOW: begin
          if (cnt == '0) begin
            st     <= SB_HOLD;
            we_n_o <= 1'b1;
            re_n_o <= 1'b1;
            if (!is_wr) begin
              rd_data_o <= din_i;
              rd_done_o <= 1'b1;
            end
          end else begin
            cnt <= cnt - PW'(1);
          end
        end
        default: begin
          st   <= SB_IDLE;
          oe_o <= 1'b0;
        end
      endcase
    end
  end

  // checker bookkeeping: length of the current write-strobe low phase
  logic [PW:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_cnt <= '0;
    else if (!we_n_o) we_low_cnt <= we_low_cnt + 1'b1;
    else we_low_cnt <= '0;
  end

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> ($past(we_low_cnt) == (PW+1)'(STROBE_CYC - 1)));

  // R5
  we_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> (oe_o && $stable(dout_o)));

  // R7
  re_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_o |-> !oe_o);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));

endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import spn_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CYC  = 2,
  parameter int SLOW_IDLE   = 1,
  parameter int FAST_IDLE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              spi_mosi2,
  input  logic              dual_lane_en,
  output logic              spi_miso,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  input  logic              nand_rb,
  output logic              host_ready,
  output logic              fan_en,
  output logic [3:0]        led_n
);
  logic              act, byte_done, first_bit, dual, tx_load, wr_req, rd_req, rd_done;
  logic [DATA_W-1:0] rx_byte, tx_byte, wr_data, rd_data;
  cfg_t              cfg;

  spn_spi_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .mosi2_i(spi_mosi2), .dual_i(dual),
    .tx_load_i(tx_load), .tx_byte_i(tx_byte), .act_o(act),
    .byte_done_o(byte_done), .first_bit_o(first_bit),
    .rx_byte_o(rx_byte), .miso_o(spi_miso)
  );

  spn_frame_ctl #(.DATA_W(DATA_W), .SLOW_IDLE(SLOW_IDLE), .FAST_IDLE(FAST_IDLE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .act_i(act), .byte_done_i(byte_done),
    .first_bit_i(first_bit), .rx_byte_i(rx_byte), .dual_sel_i(dual_lane_en),
    .rd_done_i(rd_done), .rd_data_i(rd_data), .dual_o(dual),
    .wr_req_o(wr_req), .wr_data_o(wr_data), .rd_req_o(rd_req),
    .tx_load_o(tx_load), .tx_byte_o(tx_byte), .cfg_o(cfg)
  );

  spn_nand_strobe #(.DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_strb (
    .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .din_i(nand_dq_in), .dout_o(nand_dq_out),
    .oe_o(nand_dq_oe), .we_n_o(nand_we_n), .re_n_o(nand_re_n),
    .rd_done_o(rd_done), .rd_data_o(rd_data)
  );

  assign nand_ce_n  = cfg.ce_n;
  assign nand_cle   = cfg.cle;
  assign nand_ale   = cfg.ale;
  assign fan_en     = cfg.fan;
  assign led_n      = cfg.led_n;
  assign host_ready = nand_rb;

  // R10
  ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready == nand_rb);

endmodule

// File: tb/tb_spi_nand_bridge.sv
module tb_spi_nand_bridge;
  localparam int H = 10;   // SCK half period in system clocks

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, mosi2 = 1'b0, dual_en = 1'b0;
  logic miso, dq_oe, we_n, re_n, ce_n, cle, ale, rb = 1'b1, rdy, fan;
  logic [7:0] dq_out, dq_in;
  logic [3:0] led;

  int checks = 0, errors = 0, wr_seen = 0, re_seen = 0, rd_ptr = 0, we_low = 0;
  logic [7:0] nmem [16];
  logic [7:0] wr_q[$];
  logic [7:0] we_cap;
  bit done = 0;

  always #5 clk = ~clk;

  spi_nand_bridge dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_mosi2(mosi2), .dual_lane_en(dual_en), .spi_miso(miso),
    .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_rb(rb), .host_ready(rdy), .fan_en(fan), .led_n(led)
  );

  assign dq_in = nmem[rd_ptr[3:0]];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // NAND read model: advance after each read strobe
  always @(posedge re_n) if (rst_n) begin
    rd_ptr++;
    re_seen++;
  end

  always @(posedge clk) if (!we_n) we_low++;

  // scoreboard monitor for NAND writes
  always @(negedge we_n) if (rst_n) begin
    we_low = 0;
    we_cap = dq_out;
  end
  always @(posedge we_n) if (rst_n) begin
    logic [7:0] exp;
    wr_seen++;
    check(we_low == 2, "R5 write strobe width", we_low, 2);
    check(dq_oe && dq_out == we_cap, "R5 data held across strobe", dq_out, we_cap);
    if (wr_q.size() == 0) check(0, "R4 unexpected NAND write", dq_out, 0);
    else begin
      exp = wr_q.pop_front();
      check(dq_out == exp, "R4/R6 NAND write data", dq_out, exp);
    end
  end

  task automatic spi_byte(input logic [7:0] b, input bit dual, output logic [7:0] got);
    got = '0;
    if (!dual) begin
      for (int i = 7; i >= 0; i--) begin
        @(negedge clk); mosi = b[i];
        repeat (H) @(negedge clk);
        got[i] = miso; sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
    end else begin
      for (int k = 3; k >= 0; k--) begin
        @(negedge clk); mosi = b[2*k+1]; mosi2 = b[2*k];
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
    end
  endtask

  task automatic spi_partial(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = b[i];
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int wbase, rbase;
    for (int i = 0; i < 16; i++) nmem[i] = 8'h00;
    nmem[0] = 8'h11; nmem[1] = 8'h22; nmem[2] = 8'h33; nmem[3] = 8'h44;
    nmem[4] = 8'h5E; nmem[5] = 8'h6F; nmem[6] = 8'h70;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check({ce_n, cle, ale, fan, led} == 8'h8F, "R1 settings after reset", {ce_n, cle, ale, fan, led}, 8'h8F);
    check(we_n && re_n && !miso, "R1 strobes idle and miso low", {we_n, re_n, miso}, 3'b110);

    // R3 settings write, trailing byte ignored
    cs_on(); spi_byte(8'h09, 0, g); spi_byte(8'h5A, 0, g);
    check(!ce_n && cle && !ale && fan && led == 4'hA, "R3 settings fields", {ce_n, cle, ale, fan, led}, 8'h5A);
    spi_byte(8'h33, 0, g); cs_off();
    check({ce_n, cle, ale, fan, led} == 8'h5A, "R3 extra byte ignored", {ce_n, cle, ale, fan, led}, 8'h5A);

    // R4 single-lane write, trailing response byte not written; R11 miso low
    wbase = wr_seen;
    wr_q.push_back(8'hA5); wr_q.push_back(8'h3C);
    cs_on(); spi_byte(8'h08, 0, g); spi_byte(8'hA5, 0, g); spi_byte(8'h3C, 0, g);
    spi_byte(8'hFF, 0, g);
    check(g == 8'h00, "R11 response slot miso", g, 0);
    cs_off();
    check(wr_seen - wbase == 2, "R4 write count", wr_seen - wbase, 2);

    // R6 dual-lane write
    dual_en = 1'b1;
    wbase = wr_seen;
    wr_q.push_back(8'hC3); wr_q.push_back(8'h96);
    cs_on(); spi_byte(8'h08, 0, g); spi_byte(8'hC3, 1, g); spi_byte(8'h96, 1, g);
    spi_byte(8'h00, 1, g); cs_off();
    dual_en = 1'b0;
    check(wr_seen - wbase == 2, "R6 dual write count", wr_seen - wbase, 2);
    check(wr_q.size() == 0, "R4 scoreboard drained", wr_q.size(), 0);

    // R7 read with one idle slot
    rbase = re_seen;
    cs_on(); spi_byte(8'h0A, 0, g); spi_byte(8'h00, 0, g);
    check(g == 8'h00, "R11 idle slot miso", g, 0);
    spi_byte(8'h00, 0, g); check(g == 8'h11, "R7 read byte 0", g, 8'h11);
    spi_byte(8'h00, 0, g); check(g == 8'h22, "R7 read byte 1", g, 8'h22);
    spi_byte(8'h00, 0, g); check(g == 8'h33, "R7 read byte 2", g, 8'h33);
    cs_off();
    check(re_seen - rbase == 4, "R7 read strobe count", re_seen - rbase, 4);

    // R8 fast read with four idle slots
    rbase = re_seen;
    cs_on(); spi_byte(8'h0B, 0, g);
    for (int i = 0; i < 4; i++) begin
      spi_byte(8'h00, 0, g);
      check(g == 8'h00, "R8 fast idle slot miso", g, 0);
    end
    spi_byte(8'h00, 0, g); check(g == 8'h5E, "R8 fast read byte 0", g, 8'h5E);
    spi_byte(8'h00, 0, g); check(g == 8'h6F, "R8 fast read byte 1", g, 8'h6F);
    cs_off();
    check(re_seen - rbase == 3, "R8 fast read strobe count", re_seen - rbase, 3);

    // R2 abort mid-byte, next frame starts with an opcode
    cs_on(); spi_byte(8'h09, 0, g); spi_partial(8'h00, 4); cs_off();
    check({ce_n, cle, ale, fan, led} == 8'h5A, "R2 partial byte dropped", {ce_n, cle, ale, fan, led}, 8'h5A);
    cs_on(); spi_byte(8'h09, 0, g); spi_byte(8'hE7, 0, g); cs_off();
    check({ce_n, cle, ale, fan, led} == 8'hE7, "R2 opcode after abort", {ce_n, cle, ale, fan, led}, 8'hE7);

    // R9 unknown opcode ignores the rest of the frame
    wbase = wr_seen; rbase = re_seen;
    cs_on(); spi_byte(8'h55, 0, g); spi_byte(8'h09, 0, g); spi_byte(8'h00, 0, g);
    spi_byte(8'h08, 0, g); cs_off();
    check({ce_n, cle, ale, fan, led} == 8'hE7, "R9 settings untouched", {ce_n, cle, ale, fan, led}, 8'hE7);
    check(wr_seen == wbase && re_seen == rbase, "R9 no NAND strobes", wr_seen - wbase + re_seen - rbase, 0);

    // R10 ready passthrough
    rb = 1'b0; #1; check(rdy == 1'b0, "R10 ready low", rdy, 0);
    @(negedge clk); rb = 1'b1; #1; check(rdy == 1'b1, "R10 ready high", rdy, 1);

    repeat (10) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule